// File: doc/BRIEF.md
# Speculative In-flight Target Buffer

This block sits beside an indirect-branch target predictor and covers the interval between a prediction and its retirement. Each predicted indirect branch pushes one entry at fetch time: a tag naming the predictor slot that supplied the target, and the target that fetch actually followed. When the same predictor slot is consulted again before the earlier branch retires, the slot still holds its old contents. A lookup here then returns the newer speculative target in place of the stale one. When nothing matches, the predictor's own target passes through unchanged.

Storage is a circular array of 2^LOG_DEPTH entries addressed by two pointers, both of which only move downward. The fetch pointer drops by one on every insert. The retire pointer drops by one on every retire. A lookup looks only at entries from the fetch pointer up to, but not including, whichever is smaller: the retire pointer, or the fetch pointer plus WIN. Within that window the lowest address, which holds the most recent insert, wins.

A window classifier turns the two pointers into one of three states. WIN_EMPTY means the retire pointer is at or below the fetch pointer. WIN_PART means fewer than WIN entries lie between the pointers. WIN_FULL means WIN or more lie between them. The transitions are:
- INSERT moves toward WIN_FULL.
- RETIRE moves toward WIN_EMPTY.
- INSERT together with RETIRE keeps the state.
- Reset returns to WIN_EMPTY.

Top module: `spec_target_buf`

## Requirements
- R1: Reset sets both pointers to zero and clears every entry, so after reset every lookup misses.
- R2: An insert first decrements the fetch pointer, then writes the tag and target at the new pointer modulo 2^LOG_DEPTH. A lookup in the following cycle with the same tag hits and returns that target.
- R3: Each retire decrements the retire pointer by one. The oldest entry in the window leaves it, and a lookup of that entry then misses.
- R4: A lookup examines at most WIN (8) entries: those at the fetch pointer plus 0 to 7. An entry further from the fetch pointer does not hit, even if no retire has happened.
- R5: When several window entries match, the one at the lowest pointer, which is the most recent insert, supplies the target.
- R6: On a miss, lk_target equals lk_default and lk_hit is 0.
- R7: The tag is the bank number plus the table index shifted left by 4, i.e. {index, bank} with a 4-bit bank field. Entries that differ only in bank, or only in index, never match each other.
- R8: When the retire pointer is at or below the fetch pointer, as after more retires than inserts, the window is empty and every lookup misses.
- R9: An insert and a retire in the same cycle move both pointers by one, so the window keeps its size and slides down by one entry.
- R10: Pointers are PTR_W (16) bits wide, so window membership stays correct after the storage index wraps past 2^LOG_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Fetch-side insert strobe |
| ins_bank | input | BANK_W (4) | Providing bank number of the inserted prediction |
| ins_index | input | IDX_W (12) | Providing table index of the inserted prediction |
| ins_target | input | TGT_W (32) | Speculative target to record |
| ret_valid | input | 1 | Retire-side release strobe |
| lk_bank | input | BANK_W (4) | Bank number of the lookup |
| lk_index | input | IDX_W (12) | Table index of the lookup |
| lk_default | input | TGT_W (32) | Target returned on a miss |
| lk_hit | output | 1 | A window entry matched |
| lk_target | output | TGT_W (32) | Matching target, or lk_default |

## Verification
Any error in either pointer changes the window, and the change shows up at the ports in the next cycle. An entry that should be visible comes back as a miss carrying lk_default, or a retired entry still hits. A priority error returns an older target whenever duplicate tags sit in the window. A storage addressing error shows up only after the index wraps, so the wrap sequence drives more than 2^LOG_DEPTH inserts and then probes both edges of the window.

// File: rtl/sitb_pkg.sv
package sitb_pkg;
    // Classification of the lookup window from the two pointers
    typedef enum logic [1:0] {
        WIN_EMPTY = 2'd0,
        WIN_PART  = 2'd1,
        WIN_FULL  = 2'd2
    } win_e;
endpackage

// File: rtl/sitb_ptrs.sv
module sitb_ptrs #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             ret_valid,
    output logic [PTR_W-1:0] fptr,
    output logic [PTR_W-1:0] rptr
);
    logic [PTR_W-1:0] fptr_d, rptr_d;

    always_comb begin
        fptr_d = fptr;
        rptr_d = rptr;
        if (ins_valid) fptr_d = fptr - PTR_W'(1);
        if (ret_valid) rptr_d = rptr - PTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fptr <= '0;
            rptr <= '0;
        end else begin
            fptr <= fptr_d;
            rptr <= rptr_d;
        end
    end

    // R9
    both_slide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ret_valid) |=> ((rptr - fptr) == $past(rptr - fptr)));

    // R3
    ret_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ins_valid) |=> ((rptr - fptr) == ($past(rptr - fptr) - PTR_W'(1))));
endmodule

// File: rtl/sitb_store.sv
module sitb_store #(
    parameter int LOG_DEPTH = 6,
    parameter int PTR_W     = 16,
    parameter int WIN       = 8,
    parameter int TAG_W     = 16,
    parameter int TGT_W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [LOG_DEPTH-1:0]       wr_slot,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [TGT_W-1:0]           wr_tgt,
    input  logic [PTR_W-1:0]           base,
    output logic [WIN-1:0]             rd_vld,
    output logic [WIN-1:0][TAG_W-1:0]  rd_tag,
    output logic [WIN-1:0][TGT_W-1:0]  rd_tgt
);
    localparam int DEPTH = 1 << LOG_DEPTH;

    logic [DEPTH-1:0]            vld_q;
    logic [DEPTH-1:0][TAG_W-1:0] tag_q;
    logic [DEPTH-1:0][TGT_W-1:0] tgt_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[e] <= 1'b0;
                tag_q[e] <= '0;
            end else if (wr_en && (wr_slot == LOG_DEPTH'(e))) begin
                vld_q[e] <= 1'b1;
                tag_q[e] <= wr_tag;
            end
        end
        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == LOG_DEPTH'(e))) tgt_q[e] <= wr_tgt;
        end
    end

    for (genvar k = 0; k < WIN; k++) begin : g_rd
        logic [LOG_DEPTH-1:0] slot;
        assign slot      = base[LOG_DEPTH-1:0] + LOG_DEPTH'(k);
        assign rd_vld[k] = vld_q[slot];
        assign rd_tag[k] = tag_q[slot];
        assign rd_tgt[k] = tgt_q[slot];
    end
endmodule

// File: rtl/sitb_scan.sv
module sitb_scan
    import sitb_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int WIN   = 8,
    parameter int TAG_W = 16,
    parameter int TGT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PTR_W-1:0]          fptr,
    input  logic [PTR_W-1:0]          rptr,
    input  logic [WIN-1:0]            rd_vld,
    input  logic [WIN-1:0][TAG_W-1:0] rd_tag,
    input  logic [WIN-1:0][TGT_W-1:0] rd_tgt,
    input  logic [TAG_W-1:0]          key,
    input  logic [TGT_W-1:0]          dflt,
    output logic                      hit,
    output logic [TGT_W-1:0]          target
);
    localparam int CNT_W = $clog2(WIN + 1);
    localparam int SEL_W = (WIN > 1) ? $clog2(WIN) : 1;

    logic [PTR_W-1:0] span;
    win_e             win_st;
    logic [CNT_W-1:0] cnt;
    logic [WIN-1:0]   match;
    logic [SEL_W-1:0] sel;

    assign span = rptr - fptr;

    always_comb begin
        if ($signed(span) <= 0)        win_st = WIN_EMPTY;
        else if ($signed(span) >= WIN) win_st = WIN_FULL;
        else                           win_st = WIN_PART;
    end

    always_comb begin
        unique case (win_st)
            WIN_EMPTY: cnt = '0;
            WIN_PART:  cnt = span[CNT_W-1:0];
            WIN_FULL:  cnt = CNT_W'(WIN);
            default:   cnt = '0;
        endcase
    end

    for (genvar k = 0; k < WIN; k++) begin : g_cmp
        assign match[k] = rd_vld[k] && (rd_tag[k] == key) && (CNT_W'(k) < cnt);
    end

    always_comb begin
        hit    = 1'b0;
        sel    = '0;
        target = dflt;
        for (int k = WIN - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit    = 1'b1;
                sel    = SEL_W'(k);
                target = rd_tgt[k];
            end
        end
    end

    // R8
    empty_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(rptr - fptr) <= 0) |-> !hit);

    // R4
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((CNT_W'(sel) < cnt) && ($signed(rptr - fptr) > $signed(PTR_W'(sel)))));
endmodule

// File: rtl/spec_target_buf.sv
module spec_target_buf #(
    parameter int LOG_DEPTH = 6,
    parameter int PTR_W     = 16,
    parameter int WIN       = 8,
    parameter int BANK_W    = 4,
    parameter int IDX_W     = 12,
    parameter int TGT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [BANK_W-1:0] ins_bank,
    input  logic [IDX_W-1:0]  ins_index,
    input  logic [TGT_W-1:0]  ins_target,
    input  logic              ret_valid,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [IDX_W-1:0]  lk_index,
    input  logic [TGT_W-1:0]  lk_default,
    output logic              lk_hit,
    output logic [TGT_W-1:0]  lk_target
);
    localparam int TAG_W = BANK_W + IDX_W;

    logic [PTR_W-1:0]          fptr, rptr;
    logic [TAG_W-1:0]          ins_tag, lk_tag;
    logic [LOG_DEPTH-1:0]      wr_slot;
    logic [WIN-1:0]            rd_vld;
    logic [WIN-1:0][TAG_W-1:0] rd_tag;
    logic [WIN-1:0][TGT_W-1:0] rd_tgt;

    // bank in the low field, index shifted above it
    assign ins_tag = {ins_index, ins_bank};
    assign lk_tag  = {lk_index, lk_bank};
    assign wr_slot = LOG_DEPTH'(fptr - PTR_W'(1));

    sitb_ptrs #(.PTR_W(PTR_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ret_valid(ret_valid),
        .fptr(fptr), .rptr(rptr)
    );

    sitb_store #(.LOG_DEPTH(LOG_DEPTH), .PTR_W(PTR_W), .WIN(WIN), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(ins_valid), .wr_slot(wr_slot),
        .wr_tag(ins_tag), .wr_tgt(ins_target), .base(fptr),
        .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt)
    );

    sitb_scan #(.PTR_W(PTR_W), .WIN(WIN), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .fptr(fptr), .rptr(rptr),
        .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
        .key(lk_tag), .dflt(lk_default), .hit(lk_hit), .target(lk_target)
    );

    // R2
    ins_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> (rd_vld[0] && (rd_tag[0] == $past(ins_tag)) && (rd_tgt[0] == $past(ins_target))));

    // R6
    miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == lk_default));
endmodule

// File: tb/spec_target_buf_tb.sv
module spec_target_buf_tb;
    localparam time CYC = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [3:0]  ins_bank = '0;
    logic [11:0] ins_index = '0;
    logic [31:0] ins_target = '0;
    logic        ret_valid = 1'b0;
    logic [3:0]  lk_bank = '0;
    logic [11:0] lk_index = '0;
    logic [31:0] lk_default = '0;
    logic        lk_hit;
    logic [31:0] lk_target;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    spec_target_buf u_dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_bank(ins_bank),
        .ins_index(ins_index), .ins_target(ins_target), .ret_valid(ret_valid),
        .lk_bank(lk_bank), .lk_index(lk_index), .lk_default(lk_default),
        .lk_hit(lk_hit), .lk_target(lk_target)
    );

    typedef struct packed {
        logic        ins;
        logic        ret;
        logic [3:0]  bank;
        logic [11:0] idx;
        logic [31:0] tgt;
        logic [3:0]  lbank;
        logic [11:0] lidx;
        logic [31:0] dflt;
        logic        ehit;
        logic [31:0] etgt;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,4'd0,12'd0,32'h0,    4'd1,12'd5,32'hAAAA,1'b0,32'hAAAA,8'd6}, // R6 empty after reset
        '{1'b1,1'b0,4'd1,12'd5,32'h1000, 4'd1,12'd5,32'hAAAA,1'b1,32'h1000,8'd2}, // R2 insert then hit
        '{1'b1,1'b0,4'd2,12'd5,32'h2000, 4'd1,12'd5,32'hAAAA,1'b1,32'h1000,8'd7}, // R7 bank differs
        '{1'b0,1'b0,4'd0,12'd0,32'h0,    4'd2,12'd5,32'hAAAA,1'b1,32'h2000,8'd7}, // R7
        '{1'b0,1'b0,4'd0,12'd0,32'h0,    4'd1,12'd6,32'hBBBB,1'b0,32'hBBBB,8'd7}, // R7 index differs
        '{1'b1,1'b0,4'd1,12'd5,32'h3000, 4'd1,12'd5,32'hAAAA,1'b1,32'h3000,8'd5}, // R5 newest wins
        '{1'b0,1'b0,4'd0,12'd0,32'h0,    4'd3,12'd5,32'h5555,1'b0,32'h5555,8'd6}, // R6 miss default
        '{1'b0,1'b1,4'd0,12'd0,32'h0,    4'd1,12'd5,32'hAAAA,1'b1,32'h3000,8'd3}, // R3 one retire
        '{1'b0,1'b1,4'd0,12'd0,32'h0,    4'd2,12'd5,32'hCCCC,1'b0,32'hCCCC,8'd3}, // R3 retired out
        '{1'b1,1'b1,4'd4,12'd9,32'h4000, 4'd4,12'd9,32'hAAAA,1'b1,32'h4000,8'd9}, // R9 both
        '{1'b0,1'b0,4'd0,12'd0,32'h0,    4'd1,12'd5,32'hDDDD,1'b0,32'hDDDD,8'd9}, // R9 slid out
        '{1'b0,1'b1,4'd0,12'd0,32'h0,    4'd4,12'd9,32'hEEEE,1'b0,32'hEEEE,8'd3}, // R3 window empty
        '{1'b1,1'b1,4'd4,12'd9,32'h6000, 4'd4,12'd9,32'hFFFF,1'b0,32'hFFFF,8'd8}  // R8 retire ahead
    };

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual={hit,tgt}=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit i, input bit r, input logic [3:0] b, input logic [11:0] x, input logic [31:0] t);
        @(negedge clk);
        ins_valid = i; ret_valid = r; ins_bank = b; ins_index = x; ins_target = t;
        @(posedge clk);
        #1;
        ins_valid = 1'b0; ret_valid = 1'b0;
    endtask

    task automatic look(input string req, input logic [3:0] b, input logic [11:0] x,
                        input logic [31:0] d, input bit eh, input logic [31:0] et);
        lk_bank = b; lk_index = x; lk_default = d;
        #1;
        check((lk_hit == eh) && (lk_target == et), req, {lk_hit, lk_target}, {eh, et});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CYC * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        look("R1", 4'd0, 12'd0, 32'h1234, 1'b0, 32'h1234);

        for (int v = 0; v < NV; v++) begin
            step(VECS[v].ins, VECS[v].ret, VECS[v].bank, VECS[v].idx, VECS[v].tgt);
            look($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].lbank, VECS[v].lidx,
                 VECS[v].dflt, VECS[v].ehit, VECS[v].etgt);
        end

        // R4: nine inserts, no retire; only the newest eight are visible
        do_reset();
        for (int k = 0; k < 9; k++) step(1'b1, 1'b0, 4'd0, 12'(k), 32'h100 + k);
        look("R4 oldest", 4'd0, 12'd0, 32'h77, 1'b0, 32'h77);
        look("R4 edge",   4'd0, 12'd1, 32'h77, 1'b1, 32'h101);
        look("R4 newest", 4'd0, 12'd8, 32'h77, 1'b1, 32'h108);

        // R1: reset clears visible entries
        do_reset();
        look("R1 cleared", 4'd0, 12'd8, 32'h99, 1'b0, 32'h99);
        step(1'b0, 1'b0, 4'd0, 12'd0, 32'h0);
        look("R1 stays", 4'd0, 12'd2, 32'h98, 1'b0, 32'h98);

        // R10: 70 inserts, retire after the first eight, storage wraps
        for (int k = 0; k < 70; k++) step(1'b1, (k >= 8), 4'd0, 12'(k), 32'h7000 + k);
        look("R10 newest", 4'd0, 12'd69, 32'h55, 1'b1, 32'h7045);
        look("R10 edge",   4'd0, 12'd62, 32'h55, 1'b1, 32'h703E);
        look("R10 out",    4'd0, 12'd61, 32'h55, 1'b0, 32'h55);

        finish_run();
    end
endmodule